// File: doc/BRIEF.md
# Reorder Buffer with Rename Tag Map

This block keeps a single-issue out-of-order core architecturally precise. Every instruction that is dispatched takes a slot at the tail of a circular buffer. Execution results arrive out of order and are parked in their slots. They are written to the architectural register file strictly in program order as the oldest slot becomes complete. A rename map holds, for every architectural register, the tag of the youngest in-flight producer and a flag saying whether that producer's result already sits in the buffer. Dispatch uses the map to hand each source operand either a value or a tag to wait on.

Tag 0 is reserved and means "the register file holds the value", so live slots carry tags 1 to DEPTH. When the oldest slot completes with an exception, the block drops every in-flight slot and every map entry back to zero in one cycle. It also presents the handler address to fetch. The register file and the reservation stations sit outside the block. The register file is seen through its two read values and the retire write port. The reservation stations are seen through the operand outputs and the completion port.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 1, `ret_we` and `flush_valid` are 0, and every source operand reads as ready from the register file.
- R2: Accepted dispatches receive tags 1, 2, …, DEPTH, 1, … in order, and tag 0 is never given out.
- R3: With DEPTH slots in flight, `disp_ready` is 0 and a dispatch attempt changes neither the tag sequence nor the map.
- R4: A source whose map tag is 0 is reported ready with `opX_tag` 0 and `opX_value` equal to the register file input.
- R5: A source whose producer is in flight and not complete is reported not ready, with `opX_tag` equal to the producer's tag.
- R6: A completion sets the ready-in-buffer flag of the map entry that still holds its tag. From the next cycle that source reads ready, with the completed value and `opX_tag` 0.
- R7: A completion whose tag is no longer the register's current mapping leaves the map entry unchanged (still not ready, newer tag).
- R8: Retirement is in program order: `ret_we` stays 0 while the oldest slot is incomplete, even when younger slots have completed.
- R9: When the oldest slot is complete without exception, `ret_we` is 1 with its destination and value for one cycle per slot. If the map still points at that slot, the register then reads from the register file.
- R10: Retiring a slot whose register has been renamed again leaves the newer mapping in place.
- R11: When the oldest slot completed with an exception, `flush_valid` is 1 and `flush_pc` equals HANDLER_PC for one cycle, with no retire write and no dispatch accepted. Afterwards the buffer and map are empty and tags restart at 1.
- R12: An exception on a slot that is not the oldest causes no flush until all older slots have retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | AW | Destination architectural register |
| disp_src_a | input | AW | First source register |
| disp_src_b | input | AW | Second source register |
| rf_val_a | input | XLEN | Register file value of `disp_src_a` |
| rf_val_b | input | XLEN | Register file value of `disp_src_b` |
| disp_ready | output | 1 | A dispatch is accepted this cycle |
| disp_tag | output | TW | Tag the next dispatch receives |
| opa_ready | output | 1 | First operand value is valid |
| opa_tag | output | TW | Tag to wait on (0 when ready) |
| opa_value | output | XLEN | First operand value |
| opb_ready | output | 1 | Second operand value is valid |
| opb_tag | output | TW | Tag to wait on (0 when ready) |
| opb_value | output | XLEN | Second operand value |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_tag | input | TW | Tag of the completing slot |
| cmp_value | input | XLEN | Result value |
| cmp_exc | input | 1 | Result carries an exception |
| ret_we | output | 1 | Register file write this cycle |
| ret_reg | output | AW | Register written |
| ret_value | output | XLEN | Value written |
| flush_valid | output | 1 | Exception flush this cycle |
| flush_pc | output | PCW | Handler address for fetch |

## Verification
A corrupted head or tail pointer appears as a wrong `disp_tag` or a wrong `ret_reg` within one cycle. A lost or stuck completion flag holds `ret_we` low, or raises it early, at the very cycle the head should move. A map entry cleared or set under the wrong tag shows on the next dispatch that names that register. It reads from the register file too early, or waits on a stale tag. The bench therefore sweeps many wraps of the tag space with varied completion orders, and probes operands one cycle after each map event.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_storage.sv
module rob_storage #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int XLEN  = 16,
  parameter int AW    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            alloc_en,
  input  logic [IW-1:0]   alloc_idx,
  input  logic [AW-1:0]   alloc_dest,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_val,
  input  logic            wr_exc,
  input  logic [IW-1:0]   head_idx,
  output logic            head_done,
  output logic            head_exc,
  output logic [AW-1:0]   head_dest,
  output logic [XLEN-1:0] head_val,
  input  logic [IW-1:0]   rd_idx_a,
  output logic [XLEN-1:0] rd_val_a,
  input  logic [IW-1:0]   rd_idx_b,
  output logic [XLEN-1:0] rd_val_b
);
  // value and destination arrays carry no reset so they map onto RAM
  logic [XLEN-1:0] val_mem  [DEPTH];
  logic [AW-1:0]   dest_mem [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] exc_q;

  always_ff @(posedge clk) begin
    if (wr_en) val_mem[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (alloc_en) dest_mem[alloc_idx] <= alloc_dest;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      if (alloc_en) begin
        done_q[alloc_idx] <= 1'b0;
        exc_q[alloc_idx]  <= 1'b0;
      end
      if (wr_en) begin
        done_q[wr_idx] <= 1'b1;
        exc_q[wr_idx]  <= wr_exc;
      end
    end
  end

  assign head_done = done_q[head_idx];
  assign head_exc  = exc_q[head_idx];
  assign head_dest = dest_mem[head_idx];
  assign head_val  = val_mem[head_idx];
  assign rd_val_a  = val_mem[rd_idx_a];
  assign rd_val_b  = val_mem[rd_idx_b];
endmodule

// File: rtl/rob_map.sv
module rob_map #(
  parameter int NREG = 8,
  parameter int AW   = 3,
  parameter int TW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          ren_en,
  input  logic [AW-1:0] ren_reg,
  input  logic [TW-1:0] ren_tag,
  input  logic          cmp_en,
  input  logic [TW-1:0] cmp_tag,
  input  logic          ret_en,
  input  logic [AW-1:0] ret_reg,
  input  logic [TW-1:0] ret_tag,
  input  logic [AW-1:0] rd_reg_a,
  output logic [TW-1:0] rd_tag_a,
  output logic          rd_rdy_a,
  input  logic [AW-1:0] rd_reg_b,
  output logic [TW-1:0] rd_tag_b,
  output logic          rd_rdy_b
);
  logic [NREG-1:0][TW-1:0] tag_v;
  logic [NREG-1:0]         rdy_v;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [TW-1:0] t_q;
    logic          r_q;
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        t_q <= '0;
        r_q <= 1'b0;
      end else if (ren_en && ren_reg == AW'(g)) begin
        // a new rename wins over any event for the older producer
        t_q <= ren_tag;
        r_q <= 1'b0;
      end else if (ret_en && ret_reg == AW'(g) && t_q == ret_tag) begin
        t_q <= '0;
        r_q <= 1'b0;
      end else if (cmp_en && t_q != '0 && t_q == cmp_tag) begin
        r_q <= 1'b1;
      end
    end
    assign tag_v[g] = t_q;
    assign rdy_v[g] = r_q;
  end

  assign rd_tag_a = tag_v[rd_reg_a];
  assign rd_rdy_a = rdy_v[rd_reg_a];
  assign rd_tag_b = tag_v[rd_reg_b];
  assign rd_rdy_b = rdy_v[rd_reg_b];
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int          XLEN       = 16,
  parameter int          NREG       = 8,
  parameter int          DEPTH      = 4,
  parameter int          PCW        = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100,
  localparam int         AW         = $clog2(NREG),
  localparam int         IW         = $clog2(DEPTH),
  localparam int         TW         = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_valid,
  input  logic [AW-1:0]   disp_dest,
  input  logic [AW-1:0]   disp_src_a,
  input  logic [AW-1:0]   disp_src_b,
  input  logic [XLEN-1:0] rf_val_a,
  input  logic [XLEN-1:0] rf_val_b,
  output logic            disp_ready,
  output logic [TW-1:0]   disp_tag,
  output logic            opa_ready,
  output logic [TW-1:0]   opa_tag,
  output logic [XLEN-1:0] opa_value,
  output logic            opb_ready,
  output logic [TW-1:0]   opb_tag,
  output logic [XLEN-1:0] opb_value,
  input  logic            cmp_valid,
  input  logic [TW-1:0]   cmp_tag,
  input  logic [XLEN-1:0] cmp_value,
  input  logic            cmp_exc,
  output logic            ret_we,
  output logic [AW-1:0]   ret_reg,
  output logic [XLEN-1:0] ret_value,
  output logic            flush_valid,
  output logic [PCW-1:0]  flush_pc
);
  import rob_pkg::*;

  logic [IW:0]     head_q, tail_q;
  logic            empty, full, disp_fire, cmp_fire;
  logic            head_done, head_exc;
  logic [AW-1:0]   head_dest;
  logic [XLEN-1:0] head_val, rob_val_a, rob_val_b;
  logic [TW-1:0]   head_tag, map_tag_a, map_tag_b;
  logic            map_rdy_a, map_rdy_b;
  head_act_e       head_act;

  assign empty = (head_q == tail_q);
  assign full  = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);

  always_comb begin
    head_act = HEAD_WAIT;
    if (!empty && head_done) head_act = head_exc ? HEAD_TRAP : HEAD_RETIRE;
  end

  assign flush_valid = (head_act == HEAD_TRAP);
  assign ret_we      = (head_act == HEAD_RETIRE);
  assign flush_pc    = PCW'(HANDLER_PC);
  assign disp_ready  = !full && !flush_valid;
  assign disp_fire   = disp_valid && disp_ready;
  assign cmp_fire    = cmp_valid && !flush_valid;
  assign disp_tag    = TW'(tail_q[IW-1:0]) + TW'(1);
  assign head_tag    = TW'(head_q[IW-1:0]) + TW'(1);
  assign ret_reg     = head_dest;
  assign ret_value   = head_val;

  always_ff @(posedge clk) begin
    if (rst || flush_valid) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (disp_fire) tail_q <= tail_q + (IW+1)'(1);
      if (ret_we)    head_q <= head_q + (IW+1)'(1);
    end
  end

  rob_storage #(.DEPTH(DEPTH), .IW(IW), .XLEN(XLEN), .AW(AW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_valid),
    .alloc_en  (disp_fire),
    .alloc_idx (tail_q[IW-1:0]),
    .alloc_dest(disp_dest),
    .wr_en     (cmp_fire),
    .wr_idx    (IW'(cmp_tag - TW'(1))),
    .wr_val    (cmp_value),
    .wr_exc    (cmp_exc),
    .head_idx  (head_q[IW-1:0]),
    .head_done (head_done),
    .head_exc  (head_exc),
    .head_dest (head_dest),
    .head_val  (head_val),
    .rd_idx_a  (IW'(map_tag_a - TW'(1))),
    .rd_val_a  (rob_val_a),
    .rd_idx_b  (IW'(map_tag_b - TW'(1))),
    .rd_val_b  (rob_val_b)
  );

  rob_map #(.NREG(NREG), .AW(AW), .TW(TW)) u_map (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_valid),
    .ren_en  (disp_fire),
    .ren_reg (disp_dest),
    .ren_tag (disp_tag),
    .cmp_en  (cmp_fire),
    .cmp_tag (cmp_tag),
    .ret_en  (ret_we),
    .ret_reg (head_dest),
    .ret_tag (head_tag),
    .rd_reg_a(disp_src_a),
    .rd_tag_a(map_tag_a),
    .rd_rdy_a(map_rdy_a),
    .rd_reg_b(disp_src_b),
    .rd_tag_b(map_tag_b),
    .rd_rdy_b(map_rdy_b)
  );

  // operand selection: register file, completed buffer slot, or wait tag
  assign opa_ready = (map_tag_a == '0) || map_rdy_a;
  assign opa_tag   = opa_ready ? '0 : map_tag_a;
  assign opa_value = (map_tag_a == '0) ? rf_val_a : rob_val_a;
  assign opb_ready = (map_tag_b == '0) || map_rdy_b;
  assign opb_tag   = opb_ready ? '0 : map_tag_b;
  assign opb_value = (map_tag_b == '0) ? rf_val_b : rob_val_b;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 4,
  parameter int TW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [TW-1:0] disp_tag,
  input logic          ret_we,
  input logic          flush_valid
);
  // R2: a granted dispatch never carries the reserved tag
  p_tag_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |-> (disp_tag != '0));

  // R2: granted dispatches step through the tags with wrap to 1
  p_tag_step_r2: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |=>
      (disp_tag == (($past(disp_tag) == TW'(DEPTH)) ? TW'(1) : $past(disp_tag) + TW'(1))));

  // R3: a refused dispatch consumes no tag
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready && !flush_valid) |=> $stable(disp_tag));

  // R11: a flush leaves an empty buffer restarting at tag 1
  p_flush_restart_r11: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> (disp_ready && disp_tag == TW'(1) && !ret_we && !flush_valid));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_tag   (disp_tag),
  .ret_we     (ret_we),
  .flush_valid(flush_valid)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
  localparam int XLEN  = 16;
  localparam int NREG  = 4;
  localparam int DEPTH = 4;
  localparam int PCW   = 32;
  localparam logic [31:0] HPC = 32'h0000_0100;
  localparam int AW = 2;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid;
  logic [AW-1:0] disp_dest, disp_src_a, disp_src_b;
  logic [XLEN-1:0] rf_val_a, rf_val_b;
  logic disp_ready, opa_ready, opb_ready;
  logic [TW-1:0] disp_tag, opa_tag, opb_tag;
  logic [XLEN-1:0] opa_value, opb_value;
  logic cmp_valid, cmp_exc;
  logic [TW-1:0] cmp_tag;
  logic [XLEN-1:0] cmp_value;
  logic ret_we;
  logic [AW-1:0] ret_reg;
  logic [XLEN-1:0] ret_value;
  logic flush_valid;
  logic [PCW-1:0] flush_pc;

  int nchk = 0;
  int nerr = 0;
  int cnt  = 0;

  always #2 clk = ~clk;

  rob_core #(.XLEN(XLEN), .NREG(NREG), .DEPTH(DEPTH), .PCW(PCW), .HANDLER_PC(HPC)) dut (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_src_a(disp_src_a),
    .disp_src_b(disp_src_b), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .opa_ready(opa_ready), .opa_tag(opa_tag), .opa_value(opa_value),
    .opb_ready(opb_ready), .opb_tag(opb_tag), .opb_value(opb_value),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value), .cmp_exc(cmp_exc),
    .ret_we(ret_we), .ret_reg(ret_reg), .ret_value(ret_value),
    .flush_valid(flush_valid), .flush_pc(flush_pc)
  );

  function automatic logic [XLEN-1:0] vgen(input int n);
    return XLEN'(n * 37 + 5);
  endfunction

  function automatic logic [TW-1:0] tagof(input int n);
    return TW'((n % DEPTH) + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in;
    disp_valid = 1'b0; disp_dest = '0; disp_src_a = '0; disp_src_b = '0;
    rf_val_a = '0; rf_val_b = '0;
    cmp_valid = 1'b0; cmp_tag = '0; cmp_value = '0; cmp_exc = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R4: reset state
    disp_src_a = 2'd2; rf_val_a = 16'h1234; disp_src_b = 2'd3; rf_val_b = 16'h4321;
    #1;
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 disp_tag", disp_tag, 1);
    chk("R1 ret_we", ret_we, 0);
    chk("R1 flush_valid", flush_valid, 0);
    chk("R4 opa_ready", opa_ready, 1);
    chk("R4 opa_tag", opa_tag, 0);
    chk("R4 opa_value", opa_value, 16'h1234);
    chk("R4 opb_value", opb_value, 16'h4321);
    step();

    // map sequence: two renames of r1, stale completion, retire of renamed slot
    disp_valid = 1; disp_dest = 2'd1;
    #1 chk("R2 first tag", disp_tag, 1);
    step(); cnt++;
    disp_valid = 1; disp_dest = 2'd1; disp_src_a = 2'd1;
    #1;
    chk("R5 opa_ready", opa_ready, 0);
    chk("R5 opa_tag", opa_tag, 1);
    chk("R2 second tag", disp_tag, 2);
    step(); cnt++;
    disp_src_a = 2'd1; cmp_valid = 1; cmp_tag = 3'd1; cmp_value = 16'hAAAA;
    #1;
    chk("R5 renamed tag", opa_tag, 2);
    chk("R8 head not done", ret_we, 0);
    step();
    disp_src_a = 2'd1;
    #1;
    chk("R7 stale cmp ready", opa_ready, 0);
    chk("R7 stale cmp tag", opa_tag, 2);
    chk("R9 ret_we", ret_we, 1);
    chk("R9 ret_reg", ret_reg, 1);
    chk("R9 ret_value", ret_value, 16'hAAAA);
    step();
    disp_src_a = 2'd1; cmp_valid = 1; cmp_tag = 3'd2; cmp_value = 16'hBBBB;
    #1;
    chk("R10 map kept tag", opa_tag, 2);
    chk("R10 map kept ready", opa_ready, 0);
    chk("R8 idle", ret_we, 0);
    step();
    disp_src_a = 2'd1;
    #1;
    chk("R6 ready in buffer", opa_ready, 1);
    chk("R6 tag zero", opa_tag, 0);
    chk("R6 buffer value", opa_value, 16'hBBBB);
    chk("R9 ret_value 2", ret_value, 16'hBBBB);
    chk("R9 ret_we 2", ret_we, 1);
    step();
    disp_src_a = 2'd1; rf_val_a = 16'h5555;
    #1;
    chk("R9 map cleared ready", opa_ready, 1);
    chk("R9 map cleared value", opa_value, 16'h5555);
    chk("R2 tag continues", disp_tag, 3);
    step();

    // sweep: fill, refuse, complete out of order with head last, drain
    for (int k = 0; k < 6; k++) begin
      int base;
      base = cnt;
      for (int i = 0; i < DEPTH; i++) begin
        disp_valid = 1; disp_dest = AW'(i);
        #1;
        chk("R2 tag order", disp_tag, tagof(cnt));
        chk("R3 ready while room", disp_ready, 1);
        step(); cnt++;
      end
      disp_valid = 1; disp_dest = 2'd0;
      #1 chk("R3 full refuses", disp_ready, 0);
      step();
      for (int j = 0; j < 3; j++) begin
        int p;
        p = 1 + ((k + j) % 3);
        cmp_valid = 1; cmp_tag = tagof(base + p); cmp_value = vgen(base + p);
        #1 chk("R8 head incomplete", ret_we, 0);
        step();
      end
      disp_src_a = 2'd1; disp_src_b = 2'd0;
      cmp_valid = 1; cmp_tag = tagof(base); cmp_value = vgen(base);
      #1;
      chk("R8 still waiting", ret_we, 0);
      chk("R6 sweep ready", opa_ready, 1);
      chk("R6 sweep value", opa_value, vgen(base + 1));
      chk("R5 sweep wait", opb_ready, 0);
      chk("R5 sweep tag", opb_tag, tagof(base));
      step();
      for (int p = 0; p < DEPTH; p++) begin
        #1;
        chk("R8 retire", ret_we, 1);
        chk("R9 sweep reg", ret_reg, p);
        chk("R9 sweep value", ret_value, vgen(base + p));
        step();
      end
      disp_src_a = 2'd0; rf_val_a = XLEN'(k + 16'h0F00);
      #1;
      chk("R8 drained", ret_we, 0);
      chk("R3 room again", disp_ready, 1);
      chk("R3 refused left no mapping", opa_value, k + 16'h0F00);
      chk("R3 no tag consumed", disp_tag, tagof(cnt));
      step();
    end

    // exception on a younger slot, then at the head
    begin
      logic [TW-1:0] t0, t1;
      t0 = tagof(cnt);
      t1 = tagof(cnt + 1);
      for (int i = 0; i < 3; i++) begin
        disp_valid = 1; disp_dest = AW'(i);
        #1 chk("R2 tag before trap", disp_tag, tagof(cnt));
        step(); cnt++;
      end
      cmp_valid = 1; cmp_tag = t1; cmp_value = 16'hDEAD; cmp_exc = 1;
      #1 chk("R12 no flush yet", flush_valid, 0);
      step();
      cmp_valid = 1; cmp_tag = t0; cmp_value = 16'h1111;
      #1 chk("R12 younger exc waits", flush_valid, 0);
      step();
      #1;
      chk("R12 older retires", ret_we, 1);
      chk("R12 older value", ret_value, 16'h1111);
      chk("R12 no flush during retire", flush_valid, 0);
      step();
      disp_valid = 1; disp_dest = 2'd3;
      #1;
      chk("R11 flush_valid", flush_valid, 1);
      chk("R11 flush_pc", flush_pc, HPC);
      chk("R11 no retire", ret_we, 0);
      chk("R11 no dispatch", disp_ready, 0);
      step(); cnt = 0;
      disp_src_a = 2'd2; rf_val_a = 16'h7777; disp_src_b = 2'd3; rf_val_b = 16'h8888;
      #1;
      chk("R11 tag restart", disp_tag, 1);
      chk("R11 ready after", disp_ready, 1);
      chk("R11 map cleared a", opa_ready, 1);
      chk("R11 map value a", opa_value, 16'h7777);
      chk("R11 dispatch during flush dropped", opb_value, 16'h8888);
      chk("R11 flush one cycle", flush_valid, 0);
      chk("R11 no retire after", ret_we, 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule